// File: doc/BRIEF.md
# Fault-Safe Load-Multiple Sequencer

This block carries out a load-multiple operation. It fills a wrapping run of registers in a 16-entry register file from consecutive memory elements. A single-cycle `start` pulse supplies four things: the first and last register indices, a byte base address, and a width mode. The sequencer then issues memory reads one at a time, and each read response carries a fault flag. The loaded values leave through a register-file write port that has a per-half write mask.

The operation is atomic with respect to faults. For any run longer than one register, the sequencer first reads the lowest element and the highest element and keeps both in holding registers. Nothing is written to the register file until both of those reads have returned without a fault. The run spans at most 128 bytes, so every element between the two probes lies on a page that one of the probes has already reached. The middle reads are therefore treated as unable to fault. The operation can be restarted cleanly after a fault, even when the register holding the base address is one of the registers being loaded, because that register has not been touched.

Top module: `ldm_sequencer`

## Requirements
- R1: Destination registers run from the first index to the last index, counting upward modulo 16, so 15 is followed by 0. The span is (last − first) mod 16.
- R2: When the first and last indices are equal, exactly one read is issued, at the base address. If it does not fault, exactly one write goes to that register.
- R3: For a span of 1 or more, the first read is at the base address and the second read is at base + size × span. Both responses arrive before any register write.
- R4: If either of those two reads returns with the fault flag set, `fault` pulses. No register write takes place during the whole operation, and no further read is issued.
- R5: After both probe reads succeed, the first register is written with the first probe value and then the last register with the second probe value. A span of 1 ends there.
- R6: For a span of 2 or more, the registers between the first and last are then read and written in ascending wrapped order. The read address starts at base + size and grows by size on each read. A fault flag on any of these reads is ignored.
- R7: Mode 0 and mode 1 move 32-bit elements, 4 bytes each. Modes 2 and 3 move 64-bit elements, 8 bytes each. Write-mask bit 0 enables bits 31:0 and bit 1 enables bits 63:32. Mode 0 writes the low 32 bits of the element into bits 31:0 with mask 01. Mode 1 writes it into bits 63:32 with mask 10. The 64-bit modes use mask 11. The half that is not written is driven to zero.
- R8: The indices, base address and mode are captured in the cycle `start` is accepted. Later changes on those inputs do not affect the operation.
- R9: `done` or `fault` rises for exactly one cycle to end an operation, and never both together. In the cycle after that pulse `busy` is low and a new `start` is accepted. A `start` raised while `busy` is high is ignored.
- R10: At most one read is outstanding. `mem_req` is a one-cycle pulse that is never raised while a response is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| first_idx | input | 4 | First destination register |
| last_idx | input | 4 | Last destination register |
| base_addr | input | 32 | Byte address of the first element |
| mode | input | 2 | 0: low 32-bit, 1: high 32-bit, 2/3: 64-bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse, no register changed |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_fault | input | 1 | Read response fault flag |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 4 | Register-file write index |
| rf_wmask | output | 2 | Half enables (bit 0 low, bit 1 high) |
| rf_data | output | 64 | Register-file write data |

## Verification
Two events can land in the same cycle: a middle-element response that carries the fault flag, and the register write that response triggers. The design must perform the write and must not report a fault. The bench provokes this by making the memory model flag a fault on a chosen middle address. It then judges the result by checking for `done` with no `fault`, comparing the whole register file, and confirming the full write order. The second collision is a `start` raised while an operation is running. The bench pulses `start` with different operands mid-operation and checks that the read addresses, the write order and the final file match the original operands alone.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic [1:0] {
    MODE_LO32 = 2'd0,
    MODE_HI32 = 2'd1,
    MODE_W64  = 2'd2,
    MODE_W64B = 2'd3
  } ldm_mode_e;

  // True when the mode moves 8-byte elements.
  function automatic logic mode_is_wide(input logic [1:0] m);
    return m[1];
  endfunction

  // Element size in bytes.
  function automatic logic [3:0] elem_bytes(input logic [1:0] m);
    return mode_is_wide(m) ? 4'd8 : 4'd4;
  endfunction

  // Byte offset of element n from the base.
  function automatic logic [15:0] elem_offset(input logic [7:0] n, input logic [1:0] m);
    return 16'(n) * 16'(elem_bytes(m));
  endfunction

endpackage

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen
  import ldm_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [1:0]    mode_in,
  input  logic [1:0]    mode_q,
  input  logic [IW-1:0] span,
  input  logic          advance,
  input  logic          sel_last,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      ptr_q  <= base_in;
    end else if (advance) begin
      ptr_q <= ptr_q + AW'(elem_bytes(mode_q));
    end
  end

  assign last_addr = base_q + AW'(elem_offset(8'(span), mode_q));
  assign addr      = sel_last ? last_addr : ptr_q;

  logic unused_mode;
  assign unused_mode = ^mode_in;
endmodule

// File: rtl/ldm_pack.sv
module ldm_pack
  import ldm_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] data,
  output logic [1:0]    mask
);
  localparam int HW = DW / 2;

  always_comb begin
    if (mode_is_wide(mode)) begin
      data = raw;
      mask = 2'b11;
    end else if (mode == MODE_HI32) begin
      data = {raw[HW-1:0], {HW{1'b0}}};
      mask = 2'b10;
    end else begin
      data = {{HW{1'b0}}, raw[HW-1:0]};
      mask = 2'b01;
    end
  end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int IW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] first_in,
  input  logic [IW-1:0] last_in,
  input  logic [1:0]    mode_in,
  input  logic          rsp_valid,
  input  logic          rsp_fault,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          mem_req,
  output logic          sel_last,
  output logic          load,
  output logic          advance,
  output logic [IW-1:0] span,
  output logic [1:0]    mode_q,
  output logic          rf_we,
  output logic [IW-1:0] rf_idx,
  output logic [DW-1:0] raw_data,
  output logic          ev_probe_fault,
  output logic          ev_commit,
  output logic          ev_mid_write
);
  typedef enum logic [3:0] {
    S_IDLE, S_RQ_FIRST, S_WT_FIRST, S_RQ_LAST, S_WT_LAST,
    S_WR_FIRST, S_WR_LAST, S_RQ_MID, S_WT_MID, S_DONE, S_FAULT
  } st_e;

  st_e           st;
  logic [IW-1:0] first_q, last_q, cur_q;
  logic [DW-1:0] hold_first, hold_last;
  logic          single, pair, mid_last;

  assign span     = last_q - first_q;
  assign single   = (span == '0);
  assign pair     = (span == IW'(1));
  assign mid_last = (IW'(cur_q + IW'(1)) == last_q);

  assign load           = start && (st == S_IDLE);
  assign busy           = (st != S_IDLE);
  assign done           = (st == S_DONE);
  assign fault          = (st == S_FAULT);
  assign mem_req        = (st == S_RQ_FIRST) || (st == S_RQ_LAST) || (st == S_RQ_MID);
  assign sel_last       = (st == S_RQ_LAST);
  assign ev_probe_fault = rsp_valid && rsp_fault && ((st == S_WT_FIRST) || (st == S_WT_LAST));
  assign ev_commit      = (st == S_WR_FIRST);
  assign ev_mid_write   = (st == S_WT_MID) && rsp_valid;
  assign advance        = ((st == S_WR_LAST) && !pair) || ev_mid_write;

  assign rf_we = (st == S_WR_FIRST) || (st == S_WR_LAST) || ev_mid_write;

  always_comb begin
    unique case (st)
      S_WR_FIRST: begin rf_idx = first_q; raw_data = hold_first; end
      S_WR_LAST:  begin rf_idx = last_q;  raw_data = hold_last;  end
      default:    begin rf_idx = cur_q;   raw_data = rsp_data;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      first_q    <= '0;
      last_q     <= '0;
      cur_q      <= '0;
      mode_q     <= MODE_LO32;
      hold_first <= '0;
      hold_last  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          first_q <= first_in;
          last_q  <= last_in;
          mode_q  <= mode_in;
          st      <= S_RQ_FIRST;
        end
        S_RQ_FIRST: st <= S_WT_FIRST;
        S_WT_FIRST: if (rsp_valid) begin
          if (rsp_fault) st <= S_FAULT;
          else begin
            hold_first <= rsp_data;
            st         <= single ? S_WR_FIRST : S_RQ_LAST;
          end
        end
        S_RQ_LAST: st <= S_WT_LAST;
        S_WT_LAST: if (rsp_valid) begin
          if (rsp_fault) st <= S_FAULT;
          else begin
            hold_last <= rsp_data;
            st        <= S_WR_FIRST;
          end
        end
        S_WR_FIRST: st <= single ? S_DONE : S_WR_LAST;
        S_WR_LAST: begin
          cur_q <= first_q + IW'(1);
          st    <= pair ? S_DONE : S_RQ_MID;
        end
        S_RQ_MID: st <= S_WT_MID;
        S_WT_MID: if (rsp_valid) begin
          cur_q <= cur_q + IW'(1);
          st    <= mid_last ? S_DONE : S_RQ_MID;
        end
        S_DONE:  st <= S_IDLE;
        S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldm_sequencer.sv
module ldm_sequencer
  import ldm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [$clog2(NREG)-1:0] first_idx,
  input  logic [$clog2(NREG)-1:0] last_idx,
  input  logic [AW-1:0]           base_addr,
  input  logic [1:0]              mode,
  output logic                    busy,
  output logic                    done,
  output logic                    fault,
  output logic                    mem_req,
  output logic [AW-1:0]           mem_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DW-1:0]           mem_rsp_data,
  input  logic                    mem_rsp_fault,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_idx,
  output logic [1:0]              rf_wmask,
  output logic [DW-1:0]           rf_data
);
  localparam int IW = $clog2(NREG);

  logic          load, advance, sel_last;
  logic [IW-1:0] span;
  logic [1:0]    mode_q;
  logic [DW-1:0] raw_data;
  logic          ev_probe_fault, ev_commit, ev_mid_write;

  ldm_ctrl #(.IW(IW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_in(first_idx), .last_in(last_idx), .mode_in(mode),
    .rsp_valid(mem_rsp_valid), .rsp_fault(mem_rsp_fault), .rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .fault(fault), .mem_req(mem_req),
    .sel_last(sel_last), .load(load), .advance(advance), .span(span),
    .mode_q(mode_q), .rf_we(rf_we), .rf_idx(rf_idx), .raw_data(raw_data),
    .ev_probe_fault(ev_probe_fault), .ev_commit(ev_commit), .ev_mid_write(ev_mid_write)
  );

  ldm_addr_gen #(.AW(AW), .IW(IW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(base_addr),
    .mode_in(mode), .mode_q(load ? mode : mode_q), .span(span),
    .advance(advance), .sel_last(sel_last), .addr(mem_addr)
  );

  ldm_pack #(.DW(DW)) u_pack (
    .mode(mode_q), .raw(raw_data), .data(rf_data), .mask(rf_wmask)
  );
endmodule

// File: rtl/ldm_sequencer_chk.sv
module ldm_sequencer_chk #(
  parameter int DW = 64,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] first_idx,
  input logic [IW-1:0] last_idx,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          mem_req,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_fault,
  input logic          rf_we,
  input logic [1:0]    rf_wmask,
  input logic [DW-1:0] rf_data,
  input logic          ev_probe_fault,
  input logic          ev_commit
);
  localparam int HW = DW / 2;

  logic       wrote_q, pend_q, single_q;
  logic [1:0] rsp_cnt_q;
  logic       accept;
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrote_q   <= 1'b0;
      pend_q    <= 1'b0;
      single_q  <= 1'b0;
      rsp_cnt_q <= 2'd0;
    end else begin
      if (accept) begin
        wrote_q   <= 1'b0;
        rsp_cnt_q <= 2'd0;
        single_q  <= (first_idx == last_idx);
      end else begin
        if (rf_we) wrote_q <= 1'b1;
        if (mem_rsp_valid && rsp_cnt_q != 2'd3) rsp_cnt_q <= rsp_cnt_q + 2'd1;
      end
      if (mem_req) pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
    end
  end

  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !wrote_q);
  p_probe_fault_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_fault |=> fault);
  p_probes_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !single_q) |-> (rsp_cnt_q >= 2'd2));
  p_commit_is_first_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> !wrote_q);
  p_mid_fault_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_fault && wrote_q) |=> !fault);
  p_low_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wmask == 2'b10) |-> (rf_data[HW-1:0] == '0));
  p_high_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wmask == 2'b01) |-> (rf_data[DW-1:HW] == '0));
  p_excl_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> (!done && !fault && !busy));
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);
endmodule

bind ldm_sequencer ldm_sequencer_chk #(.DW(DW), .IW($clog2(NREG))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx), .last_idx(last_idx),
  .busy(busy), .done(done), .fault(fault), .mem_req(mem_req),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fault(mem_rsp_fault),
  .rf_we(rf_we), .rf_wmask(rf_wmask), .rf_data(rf_data),
  .ev_probe_fault(ev_probe_fault), .ev_commit(ev_commit)
);

// File: tb/tb_ldm_sequencer.sv
`timescale 1ns/1ps
module tb_ldm_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  first_idx = '0, last_idx = '0;
  logic [31:0] base_addr = '0;
  logic [1:0]  mode = '0;
  logic        busy, done, fault, mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;
  logic        rf_we;
  logic [3:0]  rf_idx;
  logic [1:0]  rf_wmask;
  logic [63:0] rf_data;

  ldm_sequencer dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int cycles = 0;

  // memory model configuration
  int          lat_cfg = 0;
  logic        flt_en = 1'b0;
  logic [31:0] flt_addr = '0;

  // observation logs
  logic [63:0] rf_model [16];
  logic [31:0] req_log [40];
  logic [3:0]  wr_log [40];
  int          req_n = 0, wr_n = 0;

  function automatic logic [63:0] memval(input logic [31:0] a);
    return {a * 32'h0100_0193 ^ 32'hC3C3_0001, a + 32'h1234_5678};
  endfunction

  function automatic int esize(input logic [1:0] m);
    return m[1] ? 8 : 4;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] v,
                                        input logic [1:0] m);
    if (m[1]) return v;
    if (m == 2'd1) return {v[31:0], old[31:0]};
    return {old[63:32], v[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and register-file model
  int          cnt = 0;
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req) begin
      pend  <= 1'b1;
      paddr <= mem_addr;
      cnt   <= lat_cfg;
      if (req_n < 40) req_log[req_n] = mem_addr;
      req_n++;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= memval(paddr);
        mem_rsp_fault <= flt_en && (paddr == flt_addr);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (rf_we) begin
      for (int h = 0; h < 2; h++)
        if (rf_wmask[h]) rf_model[rf_idx][h*32 +: 32] <= rf_data[h*32 +: 32];
      if (wr_n < 40) wr_log[wr_n] = rf_idx;
      wr_n++;
    end
  end

  task automatic run_op(input logic [3:0] f, input logic [3:0] l, input logic [31:0] b,
                        input logic [1:0] m, input int lat, input logic fe,
                        input logic [31:0] fa, input bit disturb);
    logic [63:0] exp_rf [16];
    int span, sz, nreq, waitc, bad, badi;
    logic exp_fault;
    logic [31:0] last_a;
    span = int'(4'(l - f));
    sz = esize(m);
    last_a = b + 32'(span * sz);
    exp_fault = fe && ((fa == b) || (span != 0 && fa == last_a));
    for (int i = 0; i < 16; i++) exp_rf[i] = rf_model[i];
    if (!exp_fault)
      for (int k = 0; k <= span; k++)
        exp_rf[4'(f + 4'(k))] = merge(exp_rf[4'(f + 4'(k))], memval(b + 32'(k * sz)), m);
    lat_cfg = lat; flt_en = fe; flt_addr = fa;
    req_n = 0; wr_n = 0;
    @(negedge clk);
    start = 1'b1; first_idx = f; last_idx = l; base_addr = b; mode = m;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble the operands after acceptance
    first_idx = 4'($urandom); last_idx = 4'($urandom); base_addr = $urandom; mode = 2'($urandom);
    waitc = 0;
    while (!(done || fault) && waitc < 500) begin
      @(negedge clk);
      waitc++;
      start = (disturb && waitc == 3 && busy && !done && !fault);
      if (start) begin first_idx = ~f; last_idx = f; base_addr = b ^ 32'h40; end
    end
    start = 1'b0;
    check(waitc < 500, "R9 op ends", 64'(waitc), 64'd0);
    check(fault == exp_fault && done == !exp_fault, "R4/R9 outcome", {62'd0, done, fault},
          {62'd0, !exp_fault, exp_fault});
    // R3/R6: read addresses
    if (exp_fault) nreq = (fa == b) ? 1 : 2;
    else nreq = span + 1;
    check(req_n == nreq, "R2/R3/R4 read count", 64'(req_n), 64'(nreq));
    if (req_n == nreq) for (int k = 0; k < nreq; k++) begin
      logic [31:0] ea;
      ea = (k == 0) ? b : (k == 1) ? last_a : b + 32'((k - 1) * sz);
      check(req_log[k] == ea, "R3/R6 read address", 64'(req_log[k]), 64'(ea));
    end
    // R1/R5: write order
    if (exp_fault) check(wr_n == 0, "R4 no write on fault", 64'(wr_n), 64'd0);
    else begin
      check(wr_n == span + 1, "R1/R2 write count", 64'(wr_n), 64'(span + 1));
      if (wr_n == span + 1) for (int k = 0; k <= span; k++) begin
        logic [3:0] ei;
        ei = (k == 0) ? f : (k == 1) ? l : 4'(f + 4'(k - 1));
        check(wr_log[k] == ei, "R1/R5 write order", 64'(wr_log[k]), 64'(ei));
      end
    end
    // R7: final file contents
    bad = 0; badi = 0;
    for (int i = 0; i < 16; i++) if (rf_model[i] !== exp_rf[i]) begin
      if (bad == 0) badi = i;
      bad++;
    end
    check(bad == 0, "R7 register file", rf_model[badi], exp_rf[badi]);
    @(negedge clk);
    check(!done && !fault && !busy, "R9 single pulse then idle", {61'd0, done, fault, busy}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) rf_model[i] = {32'(i) * 32'h1111_1111, ~(32'(i) * 32'h0101_0101)};
    repeat (3) @(negedge clk);
    check(!busy && !done && !fault && !mem_req && !rf_we, "R9 reset idle",
          {59'd0, busy, done, fault, mem_req, rf_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_op(4'd5, 4'd5, 32'h1000, 2'd0, 1, 1'b0, 0, 0);            // R2 single
    run_op(4'd15, 4'd0, 32'h2000, 2'd1, 0, 1'b0, 0, 0);           // R1 R5 pair wrap, high half
    run_op(4'd3, 4'd2, 32'h3000, 2'd2, 2, 1'b0, 0, 0);            // full 16 wide
    run_op(4'd7, 4'd11, 32'h4000, 2'd0, 1, 1'b1, 32'h4000, 0);    // R4 first probe fault
    run_op(4'd7, 4'd11, 32'h4000, 2'd3, 1, 1'b1, 32'h4020, 0);    // R4 last probe fault
    run_op(4'd9, 4'd9, 32'h5000, 2'd2, 0, 1'b1, 32'h5000, 0);     // R2 single fault
    run_op(4'd12, 4'd3, 32'h6000, 2'd1, 1, 1'b1, 32'h6008, 0);    // R6 middle fault ignored
    run_op(4'd14, 4'd4, 32'hFFFF_FFF0, 2'd2, 0, 1'b0, 0, 1);      // R8 R9 start while busy
    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [3:0] f, l; logic [31:0] b; logic [1:0] m; int fsel, sp;
      f = 4'($urandom); l = 4'($urandom); m = 2'($urandom);
      b = {$urandom_range(0, 65535), 16'd0} | 32'($urandom_range(0, 255) * 4);
      sp = int'(4'(l - f));
      fsel = $urandom_range(0, 5);
      run_op(f, l, b, m, $urandom_range(0, 3), fsel < 3,
             (fsel == 0) ? b : (fsel == 1) ? b + 32'(sp * esize(m)) : b + 32'(esize(m)),
             ($urandom_range(0, 3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule